// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt sources that belong to a cluster of four processor cores and steers each one onto either the normal (IRQ) or the fast (FIQ) interrupt line of a core. Every core has four timer request lines and four mailbox-nonzero flags of its own. One shared graphics-side interrupt is steered to exactly one core for IRQ and to exactly one core for FIQ. Each core also has a performance-monitor request whose forwarding is switched on and off per core.

Software programs the block through a simple 32-bit register bus: a word address, a write strobe with write data, and combinational read data. For each core, two pending words show which sources are currently driving its IRQ line and which are driving its FIQ line. Every source is level-sensitive. A core's IRQ output is the registered OR of its IRQ pending word, and its FIQ output is the registered OR of its FIQ pending word, so an output follows its pending word one clock later.

Top module: `lirRouter`

## Requirements
- R1: After synchronous reset, all timer and mailbox enables, the performance-monitor forwarding mask and both graphics selectors are zero, and every IRQ and FIQ output is low. With a zero selector the graphics interrupt is pending on core 0 in both its IRQ word and its FIQ word.
- R2: Each core's timer control word is at 0x40 + 4*core and its mailbox control word is at 0x50 + 4*core. Bits [7:0] are writable and read back. Bits [31:8] read zero. An address that maps to no register reads zero.
- R3: For timer source j of core c, when bit 4+j of the timer control word is set the source appears only in bit j of the core's FIQ pending word. When bit 4+j is clear and bit j is set it appears only in bit j of the IRQ pending word. When both are clear it appears in neither.
- R4: Mailbox flag j of core c follows the same rule using the mailbox control word, and lands in pending bit 4+j.
- R5: The graphics routing word at 0x0C holds the IRQ target core in bits [1:0] and the FIQ target core in bits [3:2]. While the graphics input is high, bit 8 is set in the IRQ pending word of the IRQ target core and in the FIQ pending word of the FIQ target core, and in no other pending word.
- R6: Writing ones to bits [3:0] at 0x10 sets the matching bits of the forwarding mask. Writing ones at 0x14 clears them. Zero bits leave the mask unchanged. Both addresses read the mask in bits [3:0]. A core's performance-monitor request appears in bit 9 of its IRQ pending word only while its mask bit is set, and never in its FIQ pending word.
- R7: The IRQ pending word of a core reads at 0x60 + 4*core and the FIQ pending word at 0x70 + 4*core. These words are read-only, writes to them change nothing, and bits [31:10] read zero.
- R8: Each core's IRQ output equals the OR of its IRQ pending word in the previous cycle. Its FIQ output equals the OR of its FIQ pending word in the previous cycle.
- R9: Pending bits are level-sensitive: a pending bit is clear in the same cycle its source input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 8 | Byte address of the register access; bits [1:0] ignored |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register, combinational |
| tmrReq | input | 16 | Timer requests, four per core, core c at [4c+3:4c] |
| mbxReq | input | 16 | Mailbox-nonzero flags, four per core, core c at [4c+3:4c] |
| gpuReq | input | 1 | Shared graphics-side interrupt |
| pmuReq | input | 4 | Performance-monitor request, one per core |
| irqOut | output | 4 | Registered IRQ line per core |
| fiqOut | output | 4 | Registered FIQ line per core |

## Verification
On every cycle the assertions check the following properties:
- no timer or mailbox source is pending on both lines of a core;
- the graphics interrupt shows up on at most one core per line;
- no pending bit stays set while its source is low;
- the forwarding-mask set and clear writes take effect one cycle later;
- the outputs follow the pending words with one cycle of latency.

Other behaviour can only be shown by the bench's scenarios. These are the exact bit positions and read-back values, that writes to the pending words are ignored, that unmapped and upper bits read zero, and that FIQ enables take priority when control words are rewritten while sources are held high. Random register traffic is compared against a behavioural model on every clock.

// File: rtl/lirPkg.sv
package lirPkg;
  localparam int LIR_CORES  = 4;
  localparam int LIR_SLOTS  = 4;
  localparam int LIR_SEL_W  = $clog2(LIR_CORES);
  localparam int LIR_ADDR_W = 8;
  localparam int LIR_PEND_W = 2 * LIR_SLOTS + 2;
  localparam int LIR_CTL_W  = 2 * LIR_SLOTS;

  // address pages (busAddr[7:4]) and word offsets inside page 0/1
  localparam logic [3:0] PAGE_GLOBAL = 4'h0;
  localparam logic [3:0] PAGE_PMU    = 4'h1;
  localparam logic [3:0] PAGE_TMR    = 4'h4;
  localparam logic [3:0] PAGE_MBX    = 4'h5;
  localparam logic [3:0] PAGE_IRQP   = 4'h6;
  localparam logic [3:0] PAGE_FIQP   = 4'h7;
  localparam logic [1:0] WORD_GPU    = 2'd3;
  localparam logic [1:0] WORD_PMUSET = 2'd0;
  localparam logic [1:0] WORD_PMUCLR = 2'd1;

  typedef enum logic [2:0] {
    RD_NONE, RD_GPU, RD_PMU, RD_TMR, RD_MBX, RD_IRQP, RD_FIQP
  } lirRdKind_e;

  typedef struct packed {
    logic                  gpuWr;
    logic                  pmuSet;
    logic                  pmuClr;
    logic [LIR_CORES-1:0]  tmrWr;
    logic [LIR_CORES-1:0]  mbxWr;
    lirRdKind_e            rdKind;
    logic [LIR_SEL_W-1:0]  rdCore;
  } lirStrobe_t;
endpackage

// File: rtl/lirCoreRoute.sv
module lirCoreRoute
  import lirPkg::*;
#(
  parameter int CORE_ID = 0
) (
  input  logic [LIR_SLOTS-1:0] tmrReq,
  input  logic [LIR_SLOTS-1:0] mbxReq,
  input  logic [LIR_CTL_W-1:0] tmrCtl,
  input  logic [LIR_CTL_W-1:0] mbxCtl,
  input  logic                 gpuReq,
  input  logic [LIR_SEL_W-1:0] gpuIrqSel,
  input  logic [LIR_SEL_W-1:0] gpuFiqSel,
  input  logic                 pmuReq,
  input  logic                 pmuEn,
  output logic [LIR_PEND_W-1:0] irqPend,
  output logic [LIR_PEND_W-1:0] fiqPend
);
  localparam logic [LIR_SEL_W-1:0] MY_SEL = LIR_SEL_W'(CORE_ID);

  logic [LIR_SLOTS-1:0] tIrqEn, tFiqEn, mIrqEn, mFiqEn;
  logic [LIR_SLOTS-1:0] tIrq, tFiq, mIrq, mFiq;
  logic gpuIrqHit, gpuFiqHit;

  assign tIrqEn = tmrCtl[LIR_SLOTS-1:0];
  assign tFiqEn = tmrCtl[LIR_CTL_W-1:LIR_SLOTS];
  assign mIrqEn = mbxCtl[LIR_SLOTS-1:0];
  assign mFiqEn = mbxCtl[LIR_CTL_W-1:LIR_SLOTS];

  // fast enable wins over normal enable
  assign tFiq = tmrReq & tFiqEn;
  assign tIrq = tmrReq & tIrqEn & ~tFiqEn;
  assign mFiq = mbxReq & mFiqEn;
  assign mIrq = mbxReq & mIrqEn & ~mFiqEn;

  assign gpuIrqHit = gpuReq && (gpuIrqSel == MY_SEL);
  assign gpuFiqHit = gpuReq && (gpuFiqSel == MY_SEL);

  assign irqPend = {pmuReq & pmuEn, gpuIrqHit, mIrq, tIrq};
  assign fiqPend = {1'b0, gpuFiqHit, mFiq, tFiq};
endmodule

// File: rtl/lirCtrl.sv
module lirCtrl
  import lirPkg::*;
(
  input  logic [LIR_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  output lirStrobe_t            stb
);
  logic [3:0]           page;
  logic [LIR_SEL_W-1:0] word;
  logic [LIR_CORES-1:0] wrOneHot;

  assign page = busAddr[7:4];
  assign word = busAddr[3:2];

  always_comb begin
    wrOneHot = '0;
    for (int c = 0; c < LIR_CORES; c++) begin
      wrOneHot[c] = busWrEn && (word == LIR_SEL_W'(c));
    end
  end

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_NONE;
    stb.rdCore = word;
    unique case (page)
      PAGE_GLOBAL: begin
        if (word == WORD_GPU) begin
          stb.rdKind = RD_GPU;
          stb.gpuWr  = busWrEn;
        end
      end
      PAGE_PMU: begin
        if (word == WORD_PMUSET) begin
          stb.rdKind = RD_PMU;
          stb.pmuSet = busWrEn;
        end else if (word == WORD_PMUCLR) begin
          stb.rdKind = RD_PMU;
          stb.pmuClr = busWrEn;
        end
      end
      PAGE_TMR: begin
        stb.rdKind = RD_TMR;
        stb.tmrWr  = wrOneHot;
      end
      PAGE_MBX: begin
        stb.rdKind = RD_MBX;
        stb.mbxWr  = wrOneHot;
      end
      PAGE_IRQP: stb.rdKind = RD_IRQP;
      PAGE_FIQP: stb.rdKind = RD_FIQP;
      default:   stb.rdKind = RD_NONE;
    endcase
  end
endmodule

// File: rtl/lirDatapath.sv
module lirDatapath
  import lirPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  lirStrobe_t                      stb,
  input  logic [LIR_CTL_W-1:0]            wrData,
  input  logic [LIR_CORES*LIR_SLOTS-1:0]  tmrReq,
  input  logic [LIR_CORES*LIR_SLOTS-1:0]  mbxReq,
  input  logic                            gpuReq,
  input  logic [LIR_CORES-1:0]            pmuReq,
  output logic [DATA_W-1:0]               rdData,
  output logic [LIR_CORES-1:0]            irqOut,
  output logic [LIR_CORES-1:0]            fiqOut,
  output logic [LIR_CORES*LIR_PEND_W-1:0] irqPendFlat,
  output logic [LIR_CORES*LIR_PEND_W-1:0] fiqPendFlat,
  output logic [LIR_CORES-1:0]            pmuMask
);
  logic [LIR_CTL_W-1:0]  tmrCtl [LIR_CORES];
  logic [LIR_CTL_W-1:0]  mbxCtl [LIR_CORES];
  logic [LIR_SEL_W-1:0]  gpuIrqSel, gpuFiqSel;
  logic [LIR_PEND_W-1:0] irqPend [LIR_CORES];
  logic [LIR_PEND_W-1:0] fiqPend [LIR_CORES];

  // global routing state
  always_ff @(posedge clk) begin
    if (rst) begin
      gpuIrqSel <= '0;
      gpuFiqSel <= '0;
      pmuMask   <= '0;
    end else begin
      if (stb.gpuWr) begin
        gpuIrqSel <= wrData[LIR_SEL_W-1:0];
        gpuFiqSel <= wrData[2*LIR_SEL_W-1:LIR_SEL_W];
      end
      if (stb.pmuSet) pmuMask <= pmuMask | wrData[LIR_CORES-1:0];
      else if (stb.pmuClr) pmuMask <= pmuMask & ~wrData[LIR_CORES-1:0];
    end
  end

  for (genvar c = 0; c < LIR_CORES; c++) begin : gCore
    always_ff @(posedge clk) begin
      if (rst) begin
        tmrCtl[c] <= '0;
        mbxCtl[c] <= '0;
        irqOut[c] <= 1'b0;
        fiqOut[c] <= 1'b0;
      end else begin
        if (stb.tmrWr[c]) tmrCtl[c] <= wrData;
        if (stb.mbxWr[c]) mbxCtl[c] <= wrData;
        irqOut[c] <= |irqPend[c];
        fiqOut[c] <= |fiqPend[c];
      end
    end

    lirCoreRoute #(.CORE_ID(c)) uRoute (
      .tmrReq    (tmrReq[c*LIR_SLOTS +: LIR_SLOTS]),
      .mbxReq    (mbxReq[c*LIR_SLOTS +: LIR_SLOTS]),
      .tmrCtl    (tmrCtl[c]),
      .mbxCtl    (mbxCtl[c]),
      .gpuReq    (gpuReq),
      .gpuIrqSel (gpuIrqSel),
      .gpuFiqSel (gpuFiqSel),
      .pmuReq    (pmuReq[c]),
      .pmuEn     (pmuMask[c]),
      .irqPend   (irqPend[c]),
      .fiqPend   (fiqPend[c])
    );

    assign irqPendFlat[c*LIR_PEND_W +: LIR_PEND_W] = irqPend[c];
    assign fiqPendFlat[c*LIR_PEND_W +: LIR_PEND_W] = fiqPend[c];
  end

  // read mux, zero-extended to the bus width
  always_comb begin
    rdData = '0;
    unique case (stb.rdKind)
      RD_GPU:  rdData[2*LIR_SEL_W-1:0]  = {gpuFiqSel, gpuIrqSel};
      RD_PMU:  rdData[LIR_CORES-1:0]    = pmuMask;
      RD_TMR:  rdData[LIR_CTL_W-1:0]    = tmrCtl[stb.rdCore];
      RD_MBX:  rdData[LIR_CTL_W-1:0]    = mbxCtl[stb.rdCore];
      RD_IRQP: rdData[LIR_PEND_W-1:0]   = irqPend[stb.rdCore];
      RD_FIQP: rdData[LIR_PEND_W-1:0]   = fiqPend[stb.rdCore];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/lirRouter.sv
module lirRouter
  import lirPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CORES  = LIR_CORES,
  parameter int REQ_W  = LIR_CORES * LIR_SLOTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LIR_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [REQ_W-1:0]      tmrReq,
  input  logic [REQ_W-1:0]      mbxReq,
  input  logic                  gpuReq,
  input  logic [CORES-1:0]      pmuReq,
  output logic [CORES-1:0]      irqOut,
  output logic [CORES-1:0]      fiqOut
);
  lirStrobe_t stb;
  logic [LIR_CORES*LIR_PEND_W-1:0] irqPendFlat, fiqPendFlat;
  logic [LIR_CORES-1:0] pmuMask;
  logic unusedBits;

  assign unusedBits = ^{busAddr[1:0], busWrData[DATA_W-1:LIR_CTL_W]};

  lirCtrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  lirDatapath #(.DATA_W(DATA_W)) uData (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .wrData      (busWrData[LIR_CTL_W-1:0]),
    .tmrReq      (tmrReq),
    .mbxReq      (mbxReq),
    .gpuReq      (gpuReq),
    .pmuReq      (pmuReq),
    .rdData      (busRdData),
    .irqOut      (irqOut),
    .fiqOut      (fiqOut),
    .irqPendFlat (irqPendFlat),
    .fiqPendFlat (fiqPendFlat),
    .pmuMask     (pmuMask)
  );
endmodule

// File: rtl/lirRouterChk.sv
module lirRouterChk
  import lirPkg::*;
(
  input logic                            clk,
  input logic                            rst,
  input logic [LIR_ADDR_W-1:0]           busAddr,
  input logic                            busWrEn,
  input logic [31:0]                     busWrData,
  input logic [LIR_CORES*LIR_SLOTS-1:0]  tmrReq,
  input logic [LIR_CORES*LIR_SLOTS-1:0]  mbxReq,
  input logic [LIR_CORES-1:0]            irqOut,
  input logic [LIR_CORES-1:0]            fiqOut,
  input logic [LIR_CORES*LIR_PEND_W-1:0] irqPendFlat,
  input logic [LIR_CORES*LIR_PEND_W-1:0] fiqPendFlat,
  input logic [LIR_CORES-1:0]            pmuMask
);
  logic [LIR_CORES*LIR_SLOTS-1:0] tmrBoth, mbxBoth, tmrAny, mbxAny;
  logic [LIR_CORES-1:0] gpuIrqCol, gpuFiqCol, fiqPmuCol, irqAny, fiqAny;
  logic pmuSetWr, pmuClrWr;

  always_comb begin
    for (int c = 0; c < LIR_CORES; c++) begin
      for (int j = 0; j < LIR_SLOTS; j++) begin
        tmrBoth[c*LIR_SLOTS+j] = irqPendFlat[c*LIR_PEND_W+j] & fiqPendFlat[c*LIR_PEND_W+j];
        mbxBoth[c*LIR_SLOTS+j] = irqPendFlat[c*LIR_PEND_W+LIR_SLOTS+j]
                               & fiqPendFlat[c*LIR_PEND_W+LIR_SLOTS+j];
        tmrAny[c*LIR_SLOTS+j]  = irqPendFlat[c*LIR_PEND_W+j] | fiqPendFlat[c*LIR_PEND_W+j];
        mbxAny[c*LIR_SLOTS+j]  = irqPendFlat[c*LIR_PEND_W+LIR_SLOTS+j]
                               | fiqPendFlat[c*LIR_PEND_W+LIR_SLOTS+j];
      end
      gpuIrqCol[c] = irqPendFlat[c*LIR_PEND_W + 2*LIR_SLOTS];
      gpuFiqCol[c] = fiqPendFlat[c*LIR_PEND_W + 2*LIR_SLOTS];
      fiqPmuCol[c] = fiqPendFlat[c*LIR_PEND_W + 2*LIR_SLOTS + 1];
      irqAny[c]    = |irqPendFlat[c*LIR_PEND_W +: LIR_PEND_W];
      fiqAny[c]    = |fiqPendFlat[c*LIR_PEND_W +: LIR_PEND_W];
    end
  end

  assign pmuSetWr = busWrEn && (busAddr[7:2] == 6'h04);
  assign pmuClrWr = busWrEn && (busAddr[7:2] == 6'h05);

  assert_reset_low_R1: assert property (@(posedge clk)
    $past(rst) |-> (irqOut == '0 && fiqOut == '0 && pmuMask == '0));

  assert_tmr_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    tmrBoth == '0);

  assert_mbx_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    mbxBoth == '0);

  assert_gpu_single_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gpuIrqCol) && $onehot0(gpuFiqCol));

  assert_pmu_set_R6: assert property (@(posedge clk) disable iff (rst)
    pmuSetWr |=> ((pmuMask & $past(busWrData[LIR_CORES-1:0])) == $past(busWrData[LIR_CORES-1:0])));

  assert_pmu_clr_R6: assert property (@(posedge clk) disable iff (rst)
    pmuClrWr |=> ((pmuMask & $past(busWrData[LIR_CORES-1:0])) == '0));

  assert_pmu_no_fiq_R6: assert property (@(posedge clk) disable iff (rst)
    fiqPmuCol == '0);

  assert_out_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irqOut == $past(irqAny) && fiqOut == $past(fiqAny)));

  assert_level_R9: assert property (@(posedge clk) disable iff (rst)
    ((tmrAny & ~tmrReq) == '0) && ((mbxAny & ~mbxReq) == '0));
endmodule

bind lirRouter lirRouterChk uChk (
  .clk         (clk),
  .rst         (rst),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busWrData   (busWrData),
  .tmrReq      (tmrReq),
  .mbxReq      (mbxReq),
  .irqOut      (irqOut),
  .fiqOut      (fiqOut),
  .irqPendFlat (irqPendFlat),
  .fiqPendFlat (fiqPendFlat),
  .pmuMask     (pmuMask)
);

// File: tb/sim_lirRouter.sv
`timescale 1ns/1ps
module sim_lirRouter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [15:0] tmrReq = '0;
  logic [15:0] mbxReq = '0;
  logic        gpuReq = 1'b0;
  logic [3:0]  pmuReq = '0;
  logic [3:0]  irqOut, fiqOut;

  int nChk = 0;
  int nErr = 0;
  bit live = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] mTmr [4];
  logic [7:0] mMbx [4];
  logic [3:0] mGpu;
  logic [3:0] mPmu;
  logic [3:0] expIrq, expFiq;

  always #10 clk = ~clk;

  lirRouter u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tmrReq(tmrReq),
    .mbxReq(mbxReq), .gpuReq(gpuReq), .pmuReq(pmuReq),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] refPend(input int c, input bit fast);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      if (fast) begin
        r[j]   = tmrReq[c*4+j] & mTmr[c][4+j];
        r[4+j] = mbxReq[c*4+j] & mMbx[c][4+j];
      end else begin
        r[j]   = tmrReq[c*4+j] & mTmr[c][j] & ~mTmr[c][4+j];
        r[4+j] = mbxReq[c*4+j] & mMbx[c][j] & ~mMbx[c][4+j];
      end
    end
    if (fast) r[8] = gpuReq && (int'(mGpu[3:2]) == c);
    else begin
      r[8] = gpuReq && (int'(mGpu[1:0]) == c);
      r[9] = pmuReq[c] & mPmu[c];
    end
    return r;
  endfunction

  function automatic logic [31:0] refRead(input logic [7:0] a);
    int c = int'(a[3:2]);
    case (a[7:4])
      4'h0: return (a[3:2] == 2'd3) ? {28'd0, mGpu} : 32'd0;
      4'h1: return (a[3:2] < 2'd2) ? {28'd0, mPmu} : 32'd0;
      4'h4: return {24'd0, mTmr[c]};
      4'h5: return {24'd0, mMbx[c]};
      4'h6: return refPend(c, 0);
      4'h7: return refPend(c, 1);
      default: return 32'd0;
    endcase
  endfunction

  // model advance at each edge: outputs from pre-write state, then writes
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin mTmr[c] = '0; mMbx[c] = '0; end
      mGpu = '0; mPmu = '0; expIrq = '0; expFiq = '0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        expIrq[c] = |refPend(c, 0);
        expFiq[c] = |refPend(c, 1);
      end
      if (busWrEn) begin
        case (busAddr[7:4])
          4'h0: if (busAddr[3:2] == 2'd3) mGpu = busWrData[3:0];
          4'h1: begin
            if (busAddr[3:2] == 2'd0) mPmu = mPmu | busWrData[3:0];
            if (busAddr[3:2] == 2'd1) mPmu = mPmu & ~busWrData[3:0];
          end
          4'h4: mTmr[busAddr[3:2]] = busWrData[7:0];
          4'h5: mMbx[busAddr[3:2]] = busWrData[7:0];
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk("R8 irqOut vs model", {28'd0, irqOut}, {28'd0, expIrq});
      chk("R8 fiqOut vs model", {28'd0, fiqOut}, {28'd0, expFiq});
      chk("R7 read vs model", busRdData, refRead(busAddr));
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tick();
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk);
    #1 live = 1;
    tick();

    // R1 reset state
    chk("R1 irqOut reset", {28'd0, irqOut}, 32'd0);
    chk("R1 fiqOut reset", {28'd0, fiqOut}, 32'd0);
    rd(8'h0C, 32'h0, "R1 gpu routing reset");
    rd(8'h10, 32'h0, "R1 pmu mask reset");
    rd(8'h44, 32'h0, "R1 timer ctl reset");
    rd(8'h58, 32'h0, "R1 mbx ctl reset");
    gpuReq = 1'b1;
    rd(8'h60, 32'h100, "R1 gpu irq to core0");
    rd(8'h70, 32'h100, "R1 gpu fiq to core0");
    gpuReq = 1'b0;

    // R2 control word width and unmapped reads
    wr(8'h4C, 32'hFFFF_FFA5);
    rd(8'h4C, 32'hA5, "R2 timer ctl readback");
    rd(8'h5C, 32'h0, "R2 mbx ctl untouched");
    rd(8'h20, 32'h0, "R2 unmapped reads zero");
    wr(8'h4C, 32'h0);

    // R3 timer priority, plus R8 latency
    wr(8'h44, 32'h21);
    tmrReq = 16'h0030;
    #1 chk("R8 irqOut not yet", {28'd0, irqOut}, 32'd0);
    rd(8'h64, 32'h1, "R3 timer0 to irq");
    rd(8'h74, 32'h2, "R3 timer1 to fiq");
    tick();
    chk("R8 irqOut after one edge", {28'd0, irqOut}, 32'h2);
    chk("R8 fiqOut after one edge", {28'd0, fiqOut}, 32'h2);
    wr(8'h44, 32'h11);
    rd(8'h64, 32'h0, "R3 fiq overrides irq enable");
    rd(8'h74, 32'h1, "R3 fiq overrides irq enable");
    tmrReq = '0;

    // R4 mailbox priority and R9 level sensitivity
    wr(8'h58, 32'h84);
    mbxReq = 16'h0C00;
    rd(8'h68, 32'h40, "R4 mbx2 to irq");
    rd(8'h78, 32'h80, "R4 mbx3 to fiq");
    mbxReq = '0;
    rd(8'h68, 32'h0, "R9 pending drops with source");
    rd(8'h78, 32'h0, "R9 pending drops with source");

    // R5 graphics steering
    wr(8'h0C, 32'hE);
    rd(8'h0C, 32'hE, "R5 routing readback");
    gpuReq = 1'b1;
    rd(8'h68, 32'h100, "R5 gpu irq to core2");
    rd(8'h7C, 32'h100, "R5 gpu fiq to core3");
    rd(8'h60, 32'h0, "R5 gpu off core0 irq");
    rd(8'h70, 32'h0, "R5 gpu off core0 fiq");
    gpuReq = 1'b0;

    // R6 forwarding mask set/clear
    wr(8'h10, 32'h5);
    rd(8'h10, 32'h5, "R6 mask after set");
    rd(8'h14, 32'h5, "R6 mask at clear addr");
    wr(8'h14, 32'h1);
    rd(8'h10, 32'h4, "R6 mask after clear");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h4, "R6 zero bits keep mask");
    pmuReq = 4'hF;
    rd(8'h68, 32'h200, "R6 pmu on core2 irq");
    rd(8'h78, 32'h0, "R6 pmu never fiq");
    rd(8'h64, 32'h0, "R6 pmu masked core1");

    // R7 pending words are read-only
    wr(8'h68, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    rd(8'h68, 32'h200, "R7 irq pend write ignored");
    rd(8'h48, 32'h0, "R7 no side effect on ctl");
    rd(8'h0C, 32'hE, "R7 no side effect on routing");
    pmuReq = '0;

    // random traffic compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      tick();
      tmrReq = 16'($urandom);
      mbxReq = 16'($urandom);
      gpuReq = 1'($urandom);
      pmuReq = 4'($urandom);
      busWrData = $urandom;
      case ($urandom % 7)
        0: busAddr = 8'h0C;
        1: busAddr = 8'h10 | 8'(($urandom % 2) << 2);
        2: busAddr = 8'h40 | 8'(($urandom % 4) << 2);
        3: busAddr = 8'h50 | 8'(($urandom % 4) << 2);
        4: busAddr = 8'h60 | 8'(($urandom % 4) << 2);
        5: busAddr = 8'h70 | 8'(($urandom % 4) << 2);
        default: busAddr = 8'($urandom);
      endcase
      busWrEn = (($urandom % 4) == 0);
    end
    tick();
    busWrEn = 1'b0;
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++;
      nErr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChk, nErr);
      $finish;
    end
  end
endmodule